// File: doc/BRIEF.md
# Clock-Phased Shared-Adder Carry-Select Adder

A 16-bit carry-select adder. Each upper group of bits has a single ripple-carry adder instead of two adders running side by side. The carry into the lowest full adder of each upper group is the clock itself.

While the clock is high, every upper group adds with carry-in one. A set of level-sensitive latches follows that group's sum bits and carry-out. When the clock falls, the latches close and keep the carry-in-one result. The same adder then produces the carry-in-zero result. A 2:1 selector per group picks between the two results, steered by the carry from the group below. It takes the held result when that carry is one and the live result when it is zero.

The bit ranges of the groups are [1:0], [3:2], [6:4], [10:7] and [15:11]. The lowest group is a plain ripple adder fed by the external carry-in. Operands must be held for a full clock period, high phase followed by low phase. The result is valid late in the low phase.

Top module: `phase_csel_adder`

## Requirements
- R1: Late in the low clock phase, after the operands were held through the preceding high and low phases, `sum` equals the low 16 bits of `op_a + op_b + carry_in`.
- R2: Under the same conditions, `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: The groups break the carry chain at bits 2, 4, 7 and 11. Group 0 (bits 1:0) ripples from `carry_in`. Each higher group is selected by the carry-out of the group directly below it.
- R4: Late in the high clock phase, group 0 shows the sum of its slices plus `carry_in`. Every other group shows its own slice sum plus one, truncated to its width. `carry_out` shows the carry-out of bits 15:11 with carry-in one.
- R5: When a carry enters a group whose slice is all ones (propagate), the held carry-in-one result is selected. That carry then passes on to the next group. For example, 0xFFFF + 0x0000 + 1 gives sum 0x0000 and carry_out 1.
- R6: When no carry enters a group, its live carry-in-zero result is selected, even though the latches hold a different value.
- R7: Operands that change during the high phase, before the falling edge, still give a correct low-phase result. The latches keep only the value present at the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock; also the carry-in of every upper group |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum, valid late in the low phase |
| carry_out | output | 1 | Carry out of bit 15, valid late in the low phase |

## Verification
The bench applies carries that stop exactly at a group boundary (0x0003 + 0x0001) and carries that run through every group (0xFFFF + 1). A selector with swapped arms, or a group split at the wrong bit, would give wrong upper bits in these cases. It also samples late in the high phase and checks each group against its slice sum plus one. A group whose carry-in was tied to a constant, or whose latch enable was inverted, would fail that check. Operands change only after the rising edge, so a latch that captured at the wrong moment would hold stale data and give wrong low-phase results.

// File: rtl/phase_csel_adder.sv
module phase_csel_adder (
  input  logic        clk,
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        carry_in,
  output logic [15:0] sum,
  output logic        carry_out
);
  localparam int WIDTH = 16;
  localparam int NGRP  = 5;

  function automatic int grp_lo(input int g);
    case (g)
      0: grp_lo = 0;
      1: grp_lo = 2;
      2: grp_lo = 4;
      3: grp_lo = 7;
      4: grp_lo = 11;
      default: grp_lo = WIDTH;
    endcase
  endfunction

  logic [NGRP:1] gc;

  for (genvar g = 0; g < NGRP; g++) begin : grp
    localparam int LO = grp_lo(g);
    localparam int W  = grp_lo(g + 1) - LO;
    logic [W:0]   rc;
    logic [W-1:0] rs;

    if (g == 0) begin : base
      assign rc[0] = carry_in;
    end else begin : phased
      assign rc[0] = clk;
    end

    for (genvar i = 0; i < W; i++) begin : fa
      assign rs[i]   = op_a[LO+i] ^ op_b[LO+i] ^ rc[i];
      assign rc[i+1] = (op_a[LO+i] & op_b[LO+i]) | (rc[i] & (op_a[LO+i] ^ op_b[LO+i]));
    end

    if (g == 0) begin : plain
      assign sum[LO +: W] = rs;
      assign gc[1]        = rc[W];
    end else begin : sel
      logic [W-1:0] held_s;
      logic         held_c;
      always_latch begin
        if (clk) begin
          held_s <= rs;
          held_c <= rc[W];
        end
      end
      assign sum[LO +: W] = gc[g] ? held_s : rs;
      assign gc[g+1]      = gc[g] ? held_c : rc[W];
    end
  end

  assign carry_out = gc[NGRP];
endmodule

// File: rtl/phase_csel_adder_chk.sv
module phase_csel_adder_chk (
  input logic        clk,
  input logic [15:0] op_a,
  input logic [15:0] op_b,
  input logic        carry_in,
  input logic [15:0] sum,
  input logic        carry_out
);
  logic primed;
  initial primed = 1'b0;
  always @(posedge clk) primed <= 1'b1;

  function automatic logic [16:0] high_phase(input logic [15:0] a, input logic [15:0] b, input logic ci);
    logic c;
    logic [15:0] s;
    c = ci;
    for (int i = 0; i < 16; i++) begin
      if (i == 2 || i == 4 || i == 7 || i == 11) c = 1'b1;
      s[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return {c, s};
  endfunction

  logic [16:0] full;
  assign full = {1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in};

  // R1
  sum_low_chk: assert property (@(posedge clk) disable iff (!primed)
    sum == full[15:0]);

  // R2
  cout_low_chk: assert property (@(posedge clk) disable iff (!primed)
    carry_out == full[16]);

  // R4
  grp_high_chk: assert property (@(negedge clk) disable iff (!primed)
    sum == high_phase(op_a, op_b, carry_in)[15:0]);

  // R4
  cout_high_chk: assert property (@(negedge clk) disable iff (!primed)
    carry_out == high_phase(op_a, op_b, carry_in)[16]);
endmodule

bind phase_csel_adder phase_csel_adder_chk i_chk (
  .clk(clk), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum(sum), .carry_out(carry_out)
);

// File: tb/test_phase_csel_adder.sv
module test_phase_csel_adder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  phase_csel_adder i_phase_csel_adder (
    .clk(clk), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [16:0] exp_full(input logic [15:0] a, input logic [15:0] b, input logic ci);
    return {1'b0, a} + {1'b0, b} + {16'd0, ci};
  endfunction

  function automatic logic [16:0] exp_high(input logic [15:0] a, input logic [15:0] b, input logic ci);
    logic [16:0] r;
    r[1:0]   = 2'(a[1:0] + b[1:0] + 2'(ci));
    r[3:2]   = 2'(a[3:2] + b[3:2] + 2'd1);
    r[6:4]   = 3'(a[6:4] + b[6:4] + 3'd1);
    r[10:7]  = 4'(a[10:7] + b[10:7] + 4'd1);
    r[16:11] = {1'b0, a[15:11]} + {1'b0, b[15:11]} + 6'd1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b got=%h expected=%h", tag, op_a, op_b, carry_in, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic ci, input string tag);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; carry_in = ci;
    #(CLK_PERIOD/2 - 2);
    check({tag, " R4 high phase"}, {carry_out, sum}, exp_high(a, b, ci));
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    check({tag, " R1 sum"}, {1'b0, sum}, {1'b0, exp_full(a, b, ci)[15:0]});
    check({tag, " R2 carry"}, {16'd0, carry_out}, {16'd0, exp_full(a, b, ci)[16]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra, rb;
    logic rc;
    void'($urandom(32'd20240517));
    apply(16'h0000, 16'h0000, 1'b0, "zeros");
    apply(16'h0003, 16'h0001, 1'b0, "R3 boundary at bit 2");
    apply(16'h000C, 16'h0004, 1'b0, "R3 boundary at bit 4");
    apply(16'h0070, 16'h0010, 1'b0, "R3 boundary at bit 7");
    apply(16'h0780, 16'h0080, 1'b0, "R3 boundary at bit 11");
    apply(16'hFFFF, 16'h0000, 1'b1, "R5 propagate all groups");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R5 all ones");
    apply(16'h5555, 16'hAAAA, 1'b0, "R6 no carry anywhere");
    apply(16'h5555, 16'hAAAA, 1'b1, "R5 alternating with carry");
    apply(16'h8000, 16'h8000, 1'b0, "R2 top overflow");
    apply(16'h0FFC, 16'h0000, 1'b0, "R6 latches differ, live chosen");
    apply(16'h1234, 16'h4321, 1'b1, "R7 change in high phase");
    for (int n = 0; n < 400; n++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rc, "R7 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule